// File: doc/BRIEF.md
# Power Script Sequencer

The sequencer keeps four short scripts of power-bus instructions in an internal store that is filled through a simple write port. Every instruction pairs a 16-bit power-bus message with an 8-bit wait. When one of four power events is signalled, the matching script is run from its first slot. Each message is offered on a valid/ready port. Once the message has been accepted, the block counts the programmed number of tick-enable pulses before it offers the next one.

Event pulses are captured in per-event pending flags, so an event that arrives while a script is running is served later. When several events are pending, a fixed priority picks the next script. The message contents are never decoded here: broadcast and singular messages leave the block bit for bit as they were stored. A busy flag covers the interval from a captured event to the end of its script. A one-cycle done pulse marks the end of each script.

Top module: `pwr_script_seq`

## Requirements
- R1: After reset, busy, done and msgValid are low, and every script length is 0.
- R2: A run of script s offers the messages stored in slots 0 to len-1 of script s, in slot order. Each message is unchanged, whether bit 12 is set (broadcast) or clear (singular).
- R3: Event bit 0 (warm reset) runs script 0. Bit 1 (wakeup of groups 1 and 2) runs script 1. Bit 2 (wakeup of group 3) runs script 2. Bit 3 (sleep) runs script 3.
- R4: When several events are pending at the moment a script is chosen, the order is: bit 0 first, then bit 3, then bit 1, then bit 2.
- R5: An event pulse that arrives while a script runs, or in the cycle its own pending flag is being taken, is held and served after the current script ends.
- R6: While msgValid is high and msgReady is low, msgValid stays high and msgData does not change.
- R7: After a message is accepted with wait D, the next message, or the done pulse, appears in the cycle after the D-th following tickEn pulse. D = 0 moves on in the very next cycle. Ticks before acceptance have no effect.
- R8: A script of length 0 produces a done pulse and sends no message.
- R9: done is high for exactly one cycle after the last wait ends. busy is high from the cycle after an event is captured through the done cycle, and low after it when nothing is pending.
- R10: Instruction writes and length writes made while busy is high are ignored.
- R11: A written length above 16 is stored as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Instruction write strobe |
| wrScript | input | 2 | Script selected for an instruction write |
| wrSlot | input | 4 | Slot selected for an instruction write |
| wrMsg | input | 16 | Power-bus message to store |
| wrDelay | input | 8 | Wait, in ticks, to store |
| lenWrEn | input | 1 | Length write strobe |
| lenScript | input | 2 | Script selected for a length write |
| lenValue | input | 5 | Script length in instructions |
| trigIn | input | 4 | Power event pulses, one bit per script |
| tickEn | input | 1 | Wait-count tick enable |
| msgReady | input | 1 | Message consumer is ready |
| msgValid | output | 1 | A message is offered |
| msgData | output | 16 | Offered power-bus message |
| busy | output | 1 | A script is pending or running |
| done | output | 1 | One-cycle end-of-script pulse |

## Verification
Two things can happen in the same cycle: an event pulse for a script, and the dispatch that clears that script's pending flag. The bench provokes this by holding one event bit high for two cycles, so the second cycle lands on the dispatch edge. The expected outcome is two complete runs of that script. A write arriving in the same cycle that busy is high is also exercised. It is judged by triggering the affected script again later and comparing the messages against the contents stored before that run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_EV = 4;
  localparam int EV_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic loadDly;
    logic decDly;
    logic nextSlot;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic anyPend;
    logic grantLenZero;
    logic curDlyZero;
    logic lastSlot;
    logic cntOne;
  } seqStat_t;

  // rank k -> event index; rank 0 is served first
  function automatic logic [EV_W-1:0] prioAt(input int k);
    case (k)
      0:       prioAt = 2'd0;
      1:       prioAt = 2'd3;
      2:       prioAt = 2'd1;
      default: prioAt = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb
  import pwr_seq_pkg::*;
(
  input  logic [NUM_EV-1:0] pendIn,
  output logic [NUM_EV-1:0] grantOh,
  output logic [EV_W-1:0]   grantIdx,
  output logic              anyPend
);

  always_comb begin
    grantIdx = '0;
    for (int k = NUM_EV - 1; k >= 0; k--) begin
      if (pendIn[prioAt(k)]) grantIdx = prioAt(k);
    end
    anyPend = |pendIn;
    grantOh = anyPend ? (NUM_EV'(1) << grantIdx) : '0;
  end

  always_comb begin
    if (anyPend) begin
      AST_GRANT_PENDING: assert ($onehot(grantOh) && ((grantOh & pendIn) == grantOh)); // R4
    end
  end

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int MSG_W = 16,
  parameter int DLY_W = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LEN_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [EV_W-1:0]   wrScript,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [MSG_W-1:0]  wrMsg,
  input  logic [DLY_W-1:0]  wrDelay,
  input  logic              lenWrEn,
  input  logic [EV_W-1:0]   lenScript,
  input  logic [LEN_W-1:0]  lenValue,
  input  logic [NUM_EV-1:0] trigIn,
  input  logic              busy,
  input  seqCmd_t           cmd,
  input  logic [NUM_EV-1:0] grantOh,
  input  logic [EV_W-1:0]   grantIdx,
  input  logic              anyPend,
  output logic [NUM_EV-1:0] pendOut,
  output seqStat_t          stat,
  output logic [MSG_W-1:0]  curMsg
);

  logic [NUM_EV-1:0]            pendQ;
  logic [NUM_EV-1:0]            pendNext;
  logic [NUM_EV-1:0]            lenHit;
  logic [NUM_EV-1:0][LEN_W-1:0] lenQ;
  logic [MSG_W-1:0]             msgMem [NUM_EV][SLOTS];
  logic [DLY_W-1:0]             dlyMem [NUM_EV][SLOTS];
  logic [EV_W-1:0]              selQ;
  logic [SLOT_W-1:0]            slotQ;
  logic [DLY_W-1:0]             cntQ;
  logic [LEN_W-1:0]             lenClamped;
  logic [DLY_W-1:0]             curDly;
  logic                         storeOk;

  assign storeOk    = !busy;
  assign lenClamped = (lenValue > LEN_W'(SLOTS)) ? LEN_W'(SLOTS) : lenValue;

  for (genvar g = 0; g < NUM_EV; g++) begin : gEv
    // a new pulse wins over the clear of the dispatch cycle
    assign pendNext[g] = trigIn[g] | (pendQ[g] & ~(cmd.start & grantOh[g]));
    assign lenHit[g]   = lenWrEn && storeOk && (lenScript == EV_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= pendNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
    end else begin
      for (int e = 0; e < NUM_EV; e++) begin
        if (lenHit[e]) lenQ[e] <= lenClamped;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && storeOk) begin
      msgMem[wrScript][wrSlot] <= wrMsg;
      dlyMem[wrScript][wrSlot] <= wrDelay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      slotQ <= '0;
    end else if (cmd.start) begin
      selQ  <= grantIdx;
      slotQ <= '0;
    end else if (cmd.nextSlot) begin
      slotQ <= slotQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (cmd.loadDly) begin
      cntQ <= curDly;
    end else if (cmd.decDly) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign curMsg  = msgMem[selQ][slotQ];
  assign curDly  = dlyMem[selQ][slotQ];
  assign pendOut = pendQ;

  assign stat.anyPend      = anyPend;
  assign stat.grantLenZero = (lenQ[grantIdx] == '0);
  assign stat.curDlyZero   = (curDly == '0);
  assign stat.lastSlot     = ((LEN_W'(slotQ) + 1'b1) == lenQ[selQ]);
  assign stat.cntOne       = (cntQ == DLY_W'(1));

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lenQ)); // R10

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.decDly |-> (cntQ != '0)); // R7

  AST_STEP_IN_SCRIPT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.nextSlot |-> !stat.lastSlot); // R2

  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (|trigIn) |=> ((pendQ & $past(trigIn)) == $past(trigIn))); // R5

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  seqStat_t stat,
  input  logic     msgReady,
  input  logic     tickEn,
  output seqCmd_t  cmd,
  output logic     msgValid,
  output logic     busy,
  output logic     done
);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (stat.anyPend) begin
          cmd.start = 1'b1;
          stateNext = stat.grantLenZero ? ST_FIN : ST_SEND;
        end
      end
      ST_SEND: begin
        if (msgReady) begin
          if (!stat.curDlyZero) begin
            cmd.loadDly = 1'b1;
            stateNext   = ST_WAIT;
          end else if (stat.lastSlot) begin
            stateNext = ST_FIN;
          end else begin
            cmd.nextSlot = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (tickEn) begin
          if (!stat.cntOne) begin
            cmd.decDly = 1'b1;
          end else if (stat.lastSlot) begin
            stateNext = ST_FIN;
          end else begin
            cmd.nextSlot = 1'b1;
            stateNext    = ST_SEND;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign msgValid = (state == ST_SEND);
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE) || stat.anyPend;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid); // R6

  AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !tickEn) |=> (state == ST_WAIT)); // R7

endmodule

// File: rtl/pwr_script_seq.sv
module pwr_script_seq
  import pwr_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int MSG_W = 16,
  parameter int DLY_W = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LEN_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [EV_W-1:0]   wrScript,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [MSG_W-1:0]  wrMsg,
  input  logic [DLY_W-1:0]  wrDelay,
  input  logic              lenWrEn,
  input  logic [EV_W-1:0]   lenScript,
  input  logic [LEN_W-1:0]  lenValue,
  input  logic [NUM_EV-1:0] trigIn,
  input  logic              tickEn,
  input  logic              msgReady,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgData,
  output logic              busy,
  output logic              done
);

  seqCmd_t           cmd;
  seqStat_t          stat;
  logic [NUM_EV-1:0] pend;
  logic [NUM_EV-1:0] grantOh;
  logic [EV_W-1:0]   grantIdx;
  logic              anyPend;

  pwr_seq_arb u_arb (
    .pendIn   (pend),
    .grantOh  (grantOh),
    .grantIdx (grantIdx),
    .anyPend  (anyPend)
  );

  pwr_seq_dp #(
    .SLOTS (SLOTS),
    .MSG_W (MSG_W),
    .DLY_W (DLY_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrScript  (wrScript),
    .wrSlot    (wrSlot),
    .wrMsg     (wrMsg),
    .wrDelay   (wrDelay),
    .lenWrEn   (lenWrEn),
    .lenScript (lenScript),
    .lenValue  (lenValue),
    .trigIn    (trigIn),
    .busy      (busy),
    .cmd       (cmd),
    .grantOh   (grantOh),
    .grantIdx  (grantIdx),
    .anyPend   (anyPend),
    .pendOut   (pend),
    .stat      (stat),
    .curMsg    (msgData)
  );

  pwr_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .msgReady (msgReady),
    .tickEn   (tickEn),
    .cmd      (cmd),
    .msgValid (msgValid),
    .busy     (busy),
    .done     (done)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> $stable(msgData)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!msgValid && !done)); // R9

endmodule

// File: tb/pwr_script_seq_tb.sv
`timescale 1ns/100ps
module pwr_script_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrScript = '0;
  logic [3:0]  wrSlot = '0;
  logic [15:0] wrMsg = '0;
  logic [7:0]  wrDelay = '0;
  logic        lenWrEn = 1'b0;
  logic [1:0]  lenScript = '0;
  logic [4:0]  lenValue = '0;
  logic [3:0]  trigIn = '0;
  logic        tickEn = 1'b0;
  logic        msgReady = 1'b0;
  logic        msgValid;
  logic [15:0] msgData;
  logic        busy;
  logic        done;

  pwr_script_seq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrScript(wrScript), .wrSlot(wrSlot),
    .wrMsg(wrMsg), .wrDelay(wrDelay), .lenWrEn(lenWrEn), .lenScript(lenScript),
    .lenValue(lenValue), .trigIn(trigIn), .tickEn(tickEn), .msgReady(msgReady),
    .msgValid(msgValid), .msgData(msgData), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit readyAlways = 1'b0;
  string curTag = "R2";

  logic [15:0] bMsg [4][16];
  int          bDly [4][16];
  int          bLen [4];

  bit          expKind [$];
  logic [15:0] expMsg  [$];
  int          expDly  [$];

  bit   waiting = 1'b0;
  int   ticks = 0;
  int   lastDly = 0;
  bit   prevHold = 1'b0;
  logic [15:0] prevData = '0;

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  function automatic int ordAt(int k);
    case (k)
      0: return 0;
      1: return 3;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic void pushRun(int s);
    int n;
    n = (bLen[s] > 16) ? 16 : bLen[s];
    for (int i = 0; i < n; i++) begin
      expKind.push_back(1'b0);
      expMsg.push_back(bMsg[s][i]);
      expDly.push_back(bDly[s][i]);
    end
    expKind.push_back(1'b1);
    expMsg.push_back('0);
    expDly.push_back(0);
  endfunction

  function automatic void pushMask(logic [3:0] m);
    for (int k = 0; k < 4; k++) begin
      if (m[ordAt(k)]) pushRun(ordAt(k));
    end
  endfunction

  function automatic int randDly();
    int r;
    r = $urandom % 10;
    if (r < 3) return 0;
    if (r < 9) return 1 + ($urandom % 4);
    return 20 + ($urandom % 40);
  endfunction

  task automatic writeInstr(int s, int i, logic [15:0] m, int d, bit mirror);
    @(posedge clk); #1;
    wrEn = 1'b1; wrScript = 2'(s); wrSlot = 4'(i); wrMsg = m; wrDelay = 8'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (mirror) begin
      bMsg[s][i] = m;
      bDly[s][i] = d;
    end
  endtask

  task automatic writeLen(int s, int n, bit mirror);
    @(posedge clk); #1;
    lenWrEn = 1'b1; lenScript = 2'(s); lenValue = 5'(n);
    @(posedge clk); #1;
    lenWrEn = 1'b0;
    if (mirror) bLen[s] = n;
  endtask

  task automatic fillScript(int s, int n);
    for (int i = 0; i < 16; i++) writeInstr(s, i, 16'($urandom), randDly(), 1'b1);
    writeLen(s, n, 1'b1);
  endtask

  task automatic fire(logic [3:0] m, int hold);
    @(posedge clk); #1;
    trigIn = m;
    repeat (hold) @(posedge clk);
    #1;
    trigIn = '0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (expKind.size() != 0 || busy) @(negedge clk);
  endtask

  // background: ready and tick
  initial begin
    forever begin
      @(posedge clk); #1;
      msgReady = readyAlways ? 1'b1 : 1'($urandom % 2);
      tickEn   = 1'($urandom % 2);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finishRun();
    end
  end

  // monitor: message stream, waits, done
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevHold) begin
        chk(msgValid && (msgData == prevData), "R6", msgData, prevData);
      end
      prevHold = msgValid && !msgReady;
      prevData = msgData;
      if (waiting) begin
        if (msgValid || done) begin
          chk(ticks == lastDly, "R7", ticks, lastDly);
          waiting = 1'b0;
        end else if (tickEn) begin
          ticks++;
        end
      end
      if (msgValid && msgReady) begin
        if (expKind.size() == 0) begin
          chk(1'b0, curTag, msgData, 0);
          lastDly = 0;
        end else begin
          if (expKind[0]) chk(1'b0, curTag, msgData, 16'hffff);
          else chk(msgData == expMsg[0], curTag, msgData, expMsg[0]);
          lastDly = expDly[0];
          void'(expKind.pop_front());
          void'(expMsg.pop_front());
          void'(expDly.pop_front());
        end
        waiting = 1'b1;
        ticks = 0;
      end
      if (done) begin
        if (expKind.size() == 0) begin
          chk(1'b0, "R9", 1, 0);
        end else begin
          chk(expKind[0] == 1'b1, "R9", 0, 1);
          void'(expKind.pop_front());
          void'(expMsg.pop_front());
          void'(expDly.pop_front());
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd7781));
    for (int s = 0; s < 4; s++) begin
      bLen[s] = 0;
      for (int i = 0; i < 16; i++) begin
        bMsg[s][i] = '0;
        bDly[s][i] = 0;
      end
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(msgValid == 1'b0, "R1", msgValid, 0);

    // R1 / R8: lengths are zero after reset, so a trigger only gives done
    curTag = "R8";
    pushRun(0);
    fire(4'b0001, 1);
    waitIdle();
    chk(expKind.size() == 0, "R8", expKind.size(), 0);

    // load every script
    for (int s = 0; s < 4; s++) fillScript(s, 1 + ($urandom % 6));

    // R2: broadcast and singular messages unchanged
    writeInstr(1, 0, 16'h1234, 1, 1'b1);
    writeInstr(1, 1, 16'h2A50, 0, 1'b1);
    writeLen(1, 2, 1'b1);
    curTag = "R2";
    readyAlways = 1'b0;
    pushRun(1);
    fire(4'b0010, 1);
    waitIdle();

    // R3: each event bit picks its own script
    curTag = "R3";
    for (int s = 0; s < 4; s++) begin
      pushRun(s);
      fire(4'(1 << s), 1);
      waitIdle();
    end

    // R4: simultaneous events served in fixed order
    curTag = "R4";
    pushMask(4'b1111);
    fire(4'b1111, 1);
    waitIdle();
    pushMask(4'b0110);
    fire(4'b0110, 1);
    waitIdle();
    pushMask(4'b1010);
    fire(4'b1010, 1);
    waitIdle();

    // R5: events latched during a run
    curTag = "R5";
    fillScript(2, 8);
    pushRun(2);
    pushRun(0);
    pushRun(1);
    fire(4'b0100, 1);
    repeat (3) @(posedge clk);
    fire(4'b0010, 1);
    repeat (2) @(posedge clk);
    fire(4'b0001, 1);
    waitIdle();

    // R5: pulse landing on the dispatch edge of its own script -> two runs
    pushRun(3);
    pushRun(3);
    fire(4'b1000, 2);
    waitIdle();

    // R9: busy window and done pulse
    curTag = "R9";
    fire(4'b0001, 1);
    pushRun(0);
    @(negedge clk);
    chk(busy == 1'b1, "R9", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R9", busy, 0);
    chk(done == 1'b0, "R9", done, 0);
    waitIdle();

    // R10: writes while busy are ignored
    curTag = "R10";
    readyAlways = 1'b1;
    for (int i = 0; i < 3; i++) writeInstr(1, i, 16'($urandom), 30, 1'b1);
    writeLen(1, 3, 1'b1);
    pushRun(1);
    fire(4'b0010, 1);
    @(negedge clk);
    chk(busy == 1'b1, "R10", busy, 1);
    writeInstr(1, 0, ~bMsg[1][0], 0, 1'b0);
    writeLen(1, 1, 1'b0);
    waitIdle();
    pushRun(1);
    fire(4'b0010, 1);
    waitIdle();
    chk(expKind.size() == 0, "R10", expKind.size(), 0);
    readyAlways = 1'b0;

    // R11: oversize length clamps to 16
    curTag = "R11";
    for (int i = 0; i < 16; i++) writeInstr(2, i, 16'($urandom), $urandom % 2, 1'b1);
    writeLen(2, 31, 1'b1);
    pushRun(2);
    fire(4'b0100, 1);
    waitIdle();

    // R8: length set back to zero
    curTag = "R8";
    writeLen(3, 0, 1'b1);
    pushRun(3);
    fire(4'b1000, 1);
    waitIdle();
    chk(expKind.size() == 0, "R8", expKind.size(), 0);

    // R2 / R4 / R7: random scripts, masks and handshakes
    curTag = "R2";
    for (int it = 0; it < 24; it++) begin
      logic [3:0] m;
      fillScript($urandom % 4, $urandom % 17);
      readyAlways = 1'($urandom % 2);
      m = 4'(1 + ($urandom % 15));
      pushMask(m);
      fire(m, 1);
      waitIdle();
    end

    chk(expKind.size() == 0, "R2", expKind.size(), 0);
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule